// File: doc/BRIEF.md
# Operand Cache Data Array as On-Chip RAM

This block models the data storage of an operand cache that software can turn into directly addressable on-chip RAM. A requester presents a 32-bit address with a byte, halfword or longword access, or a 32-byte line transfer, for either a read or a write. The block decides whether the address lies in the 64 MB on-chip RAM window. It then checks the current control setting and the alignment. For a good access, it picks one of two 4 KB RAM halves and a byte offset inside that half.

A three-bit control register sets the behaviour. RAM mode needs both the cache enable and the RAM enable. A third bit picks which address bit selects the half: a low bit, so that pairs of 4 KB pages alternate between the halves, or a high bit, so that the lower and upper 32 MB of the window each map to one half. Every request gets a response exactly one cycle later. The response carries read data that is sign-extended for narrow reads, or one of three error flags. Tags, line fill, write-back and instruction storage are outside this block.

Top module: `oc_ram_window`

## Requirements
- R1: An address whose top six bits are 011111 (0x7C000000 through 0x7FFFFFFF) lies inside the window. Any other address raises `rsp_miss` and leaves the storage unchanged.
- R2: The control register bits are: bit 0 cache enable, bit 1 RAM enable, bit 2 index select. RAM mode is on only when bits 0 and 1 are both set. When RAM mode is off, an in-window request raises `rsp_unmapped` and writes nothing.
- R3: With index select clear, address bit 13 picks the half (0 or 1) and address bits [11:0] give the byte offset. Bits 12 and 14 to 25 are ignored.
- R4: With index select set, address bit 25 picks the half, so 0x7C000000–0x7DFFFFFF maps to half 0 and 0x7E000000–0x7FFFFFFF maps to half 1. Bits [11:0] give the offset.
- R5: Storage is little-endian: byte offset k holds bits [8*(k%4)+7 : 8*(k%4)] of the longword at offset k&~3. A byte write stores `req_wdata[7:0]` and a halfword write stores `req_wdata[15:0]`. No other byte changes.
- R6: A byte read returns its byte sign-extended to 32 bits. A halfword read returns its halfword sign-extended to 32 bits. A longword read returns the longword unchanged.
- R7: `req_size` encodes byte=0, halfword=1, longword=2, line=3. These sizes need alignment to 1, 2, 4 and 32 bytes. A misaligned in-window request in RAM mode raises `rsp_misalign` and changes no storage.
- R8: A line access moves the 32 bytes starting at the aligned offset. Longword i of the line sits at `req_bdata`/`rsp_bdata` bits [32*i+31 : 32*i].
- R9: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid`. At most one flag is raised, with priority miss, then unmapped, then misaligned. `rsp_rdata` and `rsp_bdata` are zero except for a good read of the matching kind.
- R10: The storage keeps its contents across control changes and across reset. A control write changes the mapping for requests from the next cycle on, so a request in the same cycle as the control write still uses the old setting.
- R11: After reset, `rsp_valid` is low and the control register is zero, so RAM mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Loads `ctl_din` into the control register |
| ctl_din | input | 3 | New control value {index select, RAM enable, cache enable} |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 longword, 3 line |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data for byte, halfword and longword writes |
| req_bdata | input | 256 | Write data for line writes |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_miss | output | 1 | Address was outside the window |
| rsp_unmapped | output | 1 | In window, but RAM mode was off |
| rsp_misalign | output | 1 | In window in RAM mode, but misaligned |
| rsp_rdata | output | 32 | Read data for byte, halfword and longword reads |
| rsp_bdata | output | 256 | Read data for line reads |

## Verification
The bench fills both halves with longwords under the low index bit, using addresses whose ignored bits are scrambled. It then reads every longword, halfword and byte back under the high index bit. A design that picked the wrong select bit, or that let an ignored bit reach the offset, would return another half's data. A design that lost contents on a mode change would return values that do not match. The narrow sweeps catch a swapped byte lane, missing sign extension, or a narrow write that overwrote its neighbours. Targeted cases cover the following:
- Misaligned writes, which must leave the words they touch unchanged.
- The last line of a half.
- Every control value in which RAM mode is off, which must not let a write through.
- A control write in the same cycle as a request, which must not yet change the result. A design that applied it at once would flag that request as unmapped.

// File: rtl/oc_ram_pkg.sv
// Shared types for the on-chip RAM view of the operand cache data array.
// Assumes: control and error fields are packed MSB-first as listed.
package oc_ram_pkg;

    // Access size carried on req_size
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LINE  = 2'd3
    } acc_size_e;

    // Control register: bit2 index select, bit1 RAM enable, bit0 cache enable
    typedef struct packed {
        logic idx_hi;
        logic ram_en;
        logic cache_en;
    } ram_ctl_t;

    // Error flags, listed in priority order
    typedef struct packed {
        logic miss;
        logic unmapped;
        logic misalign;
    } acc_err_t;

endpackage

// File: rtl/oc_ram_decode.sv
// Address decode: window check, mode check, alignment check, half select
// and offset extraction. Purely combinational.
// Assumes: the window is the aligned region whose top WIN_W address bits
// equal WIN_TAG; the half-select bit is OFS_W+1 in low-index mode and the
// bit just below the window tag in high-index mode.
module oc_ram_decode
    import oc_ram_pkg::*;
#(
    parameter int                ADDR_W  = 32,
    parameter int                WIN_W   = 6,
    parameter logic [WIN_W-1:0]  WIN_TAG = 6'h1F,
    parameter int                OFS_W   = 12,
    parameter int                LB_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  ram_ctl_t          ctl,
    output acc_err_t          err,
    output logic              half,
    output logic [OFS_W-1:0]  ofs,
    output logic              ok
);
    localparam int SEL_LO = OFS_W + 1;
    localparam int SEL_HI = ADDR_W - WIN_W - 1;

    logic in_win;
    logic mode_on;
    logic bad_align;
    logic unused_addr;

    assign in_win      = (addr[ADDR_W-1 -: WIN_W] == WIN_TAG);
    assign mode_on     = ctl.cache_en & ctl.ram_en;
    assign ofs         = addr[OFS_W-1:0];
    assign unused_addr = ^{addr[OFS_W], addr[SEL_HI-1:SEL_LO+1]};

    // Alignment requirement per access size
    always_comb begin
        unique case (size)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = addr[0];
            SZ_LONG: bad_align = |addr[1:0];
            default: bad_align = |addr[LB_W-1:0];
        endcase
    end

    // Prioritised error flags and half selection
    always_comb begin
        err.miss     = ~in_win;
        err.unmapped = in_win & ~mode_on;
        err.misalign = in_win & mode_on & bad_align;
        ok           = in_win & mode_on & ~bad_align;
        half         = ctl.idx_hi ? addr[SEL_HI] : addr[SEL_LO];
    end

endmodule

// File: rtl/oc_ram_bank.sv
// One RAM half: word-wide storage with a byte-enabled word write port,
// a whole-line write port, and asynchronous word and line read ports.
// Assumes: the word and line write ports are never both enabled in one
// cycle; contents are not cleared by reset.
module oc_ram_bank #(
    parameter int WORDS      = 1024,
    parameter int LINE_WORDS = 8
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [3:0]                 wr_be,
    input  logic [$clog2(WORDS)-1:0]   wr_idx,
    input  logic [31:0]                wr_data,
    input  logic                       ln_wr_en,
    input  logic [$clog2(WORDS)-$clog2(LINE_WORDS)-1:0] ln_idx,
    input  logic [LINE_WORDS*32-1:0]   ln_wdata,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [31:0]                rd_word,
    output logic [LINE_WORDS*32-1:0]   rd_line
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int LW_W  = $clog2(LINE_WORDS);

    logic [31:0] mem [WORDS];

    // Store byte lanes of one word, or all words of one line
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (wr_be[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
        if (ln_wr_en) begin
            for (int i = 0; i < LINE_WORDS; i++) begin
                mem[{ln_idx, LW_W'(i)}] <= ln_wdata[32*i +: 32];
            end
        end
    end

    assign rd_word = mem[rd_idx];

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_line_rd
        assign rd_line[32*g +: 32] = mem[{rd_idx[IDX_W-1:LW_W], LW_W'(g)}];
    end

endmodule

// File: rtl/oc_ram_rdfmt.sv
// Read formatter: picks the byte or halfword lane from a captured
// longword and sign-extends it; zero when the read was not good.
// Assumes: lane is the low two offset bits of an aligned request.
module oc_ram_rdfmt
    import oc_ram_pkg::*;
(
    input  logic [31:0] word,
    input  acc_size_e   size,
    input  logic [1:0]  lane,
    input  logic        ok,
    output logic [31:0] rdata
);
    logic [7:0]  b_sel;
    logic [15:0] h_sel;

    assign b_sel = word[{lane, 3'b000} +: 8];
    assign h_sel = lane[1] ? word[31:16] : word[15:0];

    // Size-dependent extension, gated by the good-read flag
    always_comb begin
        rdata = '0;
        if (ok) begin
            unique case (size)
                SZ_BYTE: rdata = {{24{b_sel[7]}}, b_sel};
                SZ_HALF: rdata = {{16{h_sel[15]}}, h_sel};
                SZ_LONG: rdata = word;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/oc_ram_window.sv
// Top: on-chip RAM view of the operand cache data array. Holds the control
// register, decodes each request, steers writes into one of two halves and
// returns a registered response one cycle after every request.
// Assumes: at most one request per cycle; a control write applies from the
// next cycle; storage is never cleared.
module oc_ram_window
    import oc_ram_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter int               WIN_W      = 6,
    parameter logic [WIN_W-1:0] WIN_TAG    = 6'h1F,
    parameter int               HALF_BYTES = 4096,
    parameter int               LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_we,
    input  logic [2:0]              ctl_din,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [31:0]             req_wdata,
    input  logic [LINE_BYTES*8-1:0] req_bdata,
    output logic                    rsp_valid,
    output logic                    rsp_miss,
    output logic                    rsp_unmapped,
    output logic                    rsp_misalign,
    output logic [31:0]             rsp_rdata,
    output logic [LINE_BYTES*8-1:0] rsp_bdata
);
    localparam int OFS_W      = $clog2(HALF_BYTES);
    localparam int LB_W       = $clog2(LINE_BYTES);
    localparam int WORDS      = HALF_BYTES / 4;
    localparam int IDX_W      = OFS_W - 2;
    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int LINE_BITS  = LINE_BYTES * 8;

    ram_ctl_t            ctl_q;
    acc_size_e           size;
    acc_err_t            err;
    logic                half;
    logic [OFS_W-1:0]    ofs;
    logic                ok;
    logic [3:0]          be;
    logic [31:0]         wd;
    logic [31:0]         bank_word [2];
    logic [LINE_BITS-1:0] bank_line [2];

    acc_err_t            err_q;
    logic                rd_ok_q;
    acc_size_e           size_q;
    logic [1:0]          lane_q;
    logic [31:0]         word_q;
    logic [LINE_BITS-1:0] line_q;

    assign size = acc_size_e'(req_size);

    // Control register; new value governs requests from the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ram_ctl_t'(ctl_din);
    end

    oc_ram_decode #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .WIN_TAG(WIN_TAG),
        .OFS_W  (OFS_W),
        .LB_W   (LB_W)
    ) u_decode (
        .addr (req_addr),
        .size (size),
        .ctl  (ctl_q),
        .err  (err),
        .half (half),
        .ofs  (ofs),
        .ok   (ok)
    );

    // Byte enables and lane-replicated write data for narrow writes
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be = 4'b0001 << ofs[1:0];
                wd = {4{req_wdata[7:0]}};
            end
            SZ_HALF: begin
                be = ofs[1] ? 4'b1100 : 4'b0011;
                wd = {2{req_wdata[15:0]}};
            end
            default: begin
                be = 4'b1111;
                wd = req_wdata;
            end
        endcase
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic sel;
        assign sel = req_valid & req_write & ok & (half == 1'(h));

        oc_ram_bank #(
            .WORDS     (WORDS),
            .LINE_WORDS(LINE_WORDS)
        ) u_bank (
            .clk      (clk),
            .wr_en    (sel & (size != SZ_LINE)),
            .wr_be    (be),
            .wr_idx   (ofs[OFS_W-1:2]),
            .wr_data  (wd),
            .ln_wr_en (sel & (size == SZ_LINE)),
            .ln_idx   (ofs[OFS_W-1:LB_W]),
            .ln_wdata (req_bdata),
            .rd_idx   (ofs[OFS_W-1:2]),
            .rd_word  (bank_word[h]),
            .rd_line  (bank_line[h])
        );
    end

    // Response stage: capture flags and read data one cycle after request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            err_q     <= '0;
            rd_ok_q   <= 1'b0;
            size_q    <= SZ_BYTE;
            lane_q    <= '0;
            word_q    <= '0;
            line_q    <= '0;
        end else begin
            rsp_valid <= req_valid;
            err_q     <= req_valid ? err : '0;
            rd_ok_q   <= req_valid & ~req_write & ok;
            size_q    <= size;
            lane_q    <= ofs[1:0];
            if (req_valid & ~req_write & ok) begin
                word_q <= bank_word[half];
                line_q <= bank_line[half];
            end
        end
    end

    oc_ram_rdfmt u_rdfmt (
        .word  (word_q),
        .size  (size_q),
        .lane  (lane_q),
        .ok    (rd_ok_q),
        .rdata (rsp_rdata)
    );

    assign rsp_bdata    = (rd_ok_q && size_q == SZ_LINE) ? line_q : '0;
    assign rsp_miss     = err_q.miss;
    assign rsp_unmapped = err_q.unmapped;
    assign rsp_misalign = err_q.misalign;

    logic [IDX_W-1:0] unused_idx_chk;
    assign unused_idx_chk = ofs[OFS_W-1:2];

endmodule

// File: rtl/oc_ram_window_chk.sv
// Protocol checker for oc_ram_window, attached by bind. Observes the
// request ports, the control register and the response ports.
// Assumes: the window is the region whose top WIN_W bits equal WIN_TAG.
module oc_ram_window_chk #(
    parameter int               ADDR_W    = 32,
    parameter int               WIN_W     = 6,
    parameter logic [WIN_W-1:0] WIN_TAG   = 6'h1F,
    parameter int               LINE_BITS = 256
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [1:0]           req_size,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [2:0]           ctl_q,
    input logic                 rsp_valid,
    input logic                 rsp_miss,
    input logic                 rsp_unmapped,
    input logic                 rsp_misalign,
    input logic [31:0]          rsp_rdata,
    input logic [LINE_BITS-1:0] rsp_bdata
);
    logic in_win;
    logic mode_on;
    logic any_err;
    logic unused_chk;

    assign in_win     = (req_addr[ADDR_W-1 -: WIN_W] == WIN_TAG);
    assign mode_on    = ctl_q[0] & ctl_q[1];
    assign any_err    = rsp_miss | rsp_unmapped | rsp_misalign;
    assign unused_chk = ^req_addr[ADDR_W-WIN_W-1:2];

    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r9_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_miss, rsp_unmapped, rsp_misalign}));

    a_r9_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && any_err) |-> (rsp_rdata == '0 && rsp_bdata == '0));

    a_r1_outside_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_win) |=> rsp_miss);

    a_r2_mode_off_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win && !mode_on) |=> rsp_unmapped);

    a_r7_long_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win && mode_on && req_size == 2'd2 && req_addr[1:0] != 2'b00)
        |=> rsp_misalign);

    a_r6_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !any_err && $past(req_size) == 2'd0 && !$past(req_write))
        |-> (rsp_rdata[31:8] == {24{rsp_rdata[7]}}));

endmodule

bind oc_ram_window oc_ram_window_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_W    (WIN_W),
    .WIN_TAG  (WIN_TAG),
    .LINE_BITS(LINE_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .ctl_q       (ctl_q),
    .rsp_valid   (rsp_valid),
    .rsp_miss    (rsp_miss),
    .rsp_unmapped(rsp_unmapped),
    .rsp_misalign(rsp_misalign),
    .rsp_rdata   (rsp_rdata),
    .rsp_bdata   (rsp_bdata)
);

// File: tb/oc_ram_window_bench.sv
// Sweep bench for oc_ram_window: fills both halves, reads back at every
// size under the other index mode, then probes the corner cases.
module oc_ram_window_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ctl_we;
    logic [2:0]   ctl_din;
    logic         req_valid;
    logic         req_write;
    logic [1:0]   req_size;
    logic [31:0]  req_addr;
    logic [31:0]  req_wdata;
    logic [255:0] req_bdata;
    logic         rsp_valid, rsp_miss, rsp_unmapped, rsp_misalign;
    logic [31:0]  rsp_rdata;
    logic [255:0] rsp_bdata;

    logic [3:0]   r_flags;
    logic [31:0]  r_data;
    logic [255:0] r_line;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam logic [31:0] BASE = 32'h7C00_0000;

    oc_ram_window u_oc_ram_window (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_din(ctl_din),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bdata(req_bdata),
        .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_unmapped(rsp_unmapped),
        .rsp_misalign(rsp_misalign), .rsp_rdata(rsp_rdata), .rsp_bdata(rsp_bdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input int h, input int w);
        logic [31:0] k;
        k = 32'(h * 1024 + w + 1);
        return k * 32'h9E37_79B9;
    endfunction

    // Low-index-mode address with scrambled ignored bits
    function automatic logic [31:0] a0(input int h, input int ofs);
        logic [31:0] junk;
        junk = 32'((ofs * 7 + h) & 12'hFFF);
        return BASE | (junk << 14) | (32'(h) << 13) | (32'((ofs >> 2) & 1) << 12) | 32'(ofs);
    endfunction

    // High-index-mode address with scrambled ignored bits
    function automatic logic [31:0] a1(input int h, input int ofs);
        logic [31:0] junk;
        junk = 32'((ofs * 3) & 13'h1FFF);
        return BASE | (32'(h) << 25) | (junk << 12) | 32'(ofs);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic req(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wdat, input logic [255:0] bdat,
                       input bit cw, input logic [2:0] cv);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wdat; req_bdata = bdat; ctl_we = cw; ctl_din = cv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; ctl_we = 1'b0;
        r_flags = {rsp_valid, rsp_miss, rsp_unmapped, rsp_misalign};
        r_data  = rsp_rdata;
        r_line  = rsp_bdata;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [31:0] a);
        req(1'b0, sz, a, '0, '0, 1'b0, 3'b000);
    endtask

    task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        req(1'b1, sz, a, d, '0, 1'b0, 3'b000);
    endtask

    task automatic set_ctl(input logic [2:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_din = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] line;
        logic [31:0]  p, e;
        logic [2:0]   off_vals [6];
        rst_n = 1'b0; ctl_we = 1'b0; ctl_din = '0; req_valid = 1'b0;
        req_write = 1'b0; req_size = '0; req_addr = '0; req_wdata = '0; req_bdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state, control cleared so RAM mode is off
        check("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        rd(2'd2, a0(0, 0));
        check("R11 control zero -> unmapped", {28'd0, r_flags}, 32'b1010);

        // R3: fill both halves in low-index mode
        set_ctl(3'b011);
        for (int h = 0; h < 2; h++) begin
            for (int w = 0; w < 1024; w++) begin
                wr(2'd2, a0(h, w * 4), pat(h, w));
                check("R3 fill write flags", {28'd0, r_flags}, 32'b1000);
            end
        end

        // R4 R10: read back every longword in high-index mode
        set_ctl(3'b111);
        for (int h = 0; h < 2; h++) begin
            for (int w = 0; w < 1024; w++) begin
                rd(2'd2, a1(h, w * 4));
                check("R4 R10 long readback", r_data, pat(h, w));
            end
        end

        // R6 R5: every halfword and byte, sign-extended from its lane
        for (int h = 0; h < 2; h++) begin
            for (int o = 0; o < 4096; o += 2) begin
                p = pat(h, o >> 2);
                e = (o & 2) ? {{16{p[31]}}, p[31:16]} : {{16{p[15]}}, p[15:0]};
                rd(2'd1, a1(h, o));
                check("R6 halfword sweep", r_data, e);
            end
            for (int o = 0; o < 4096; o++) begin
                p = pat(h, o >> 2);
                e = {{24{p[8*(o%4)+7]}}, p[8*(o%4) +: 8]};
                rd(2'd0, a1(h, o));
                check("R5 R6 byte sweep", r_data, e);
            end
        end

        // R5: narrow writes touch only their lanes
        set_ctl(3'b011);
        wr(2'd0, a0(1, 12'h101), 32'h1234_56F0);
        rd(2'd2, a0(1, 12'h100));
        check("R5 byte write lane1", r_data, (pat(1, 12'h40) & 32'hFFFF_00FF) | 32'h0000_F000);
        wr(2'd1, a0(0, 12'h202), 32'hABCD_8001);
        rd(2'd2, a0(0, 12'h200));
        check("R5 halfword write upper", r_data, (pat(0, 12'h80) & 32'h0000_FFFF) | 32'h8001_0000);
        rd(2'd1, a0(0, 12'h202));
        check("R6 halfword negative", r_data, 32'hFFFF_8001);
        rd(2'd0, a0(0, 12'h203));
        check("R6 byte negative", r_data, 32'hFFFF_FF80);
        rd(2'd0, a0(0, 12'h202));
        check("R6 byte positive", r_data, 32'h0000_0001);

        // R7: misaligned requests flag and store nothing
        wr(2'd2, a0(0, 12'h301), 32'h0);
        check("R7 long write misalign flag", {28'd0, r_flags}, 32'b1001);
        rd(2'd2, a0(0, 12'h300));
        check("R7 long misalign no store", r_data, pat(0, 12'hC0));
        wr(2'd1, a0(0, 12'h401), 32'h0);
        check("R7 half write misalign flag", {28'd0, r_flags}, 32'b1001);
        rd(2'd2, a0(0, 12'h400));
        check("R7 half misalign no store", r_data, pat(0, 12'h100));
        req(1'b1, 2'd3, a0(0, 12'h024), 32'h0, '0, 1'b0, 3'b000);
        check("R7 line write misalign flag", {28'd0, r_flags}, 32'b1001);
        rd(2'd2, a0(0, 12'h024));
        check("R7 line misalign no store", r_data, pat(0, 9));
        rd(2'd2, a0(0, 12'h003));
        check("R7 R9 misaligned read flags", {28'd0, r_flags}, 32'b1001);
        check("R9 misaligned read data zero", r_data, 32'h0);

        // R8: line write into the last line of half 1, line reads
        for (int i = 0; i < 8; i++) line[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
        req(1'b1, 2'd3, a0(1, 12'hFE0), 32'h0, line, 1'b0, 3'b000);
        check("R8 line write flags", {28'd0, r_flags}, 32'b1000);
        for (int i = 0; i < 8; i++) begin
            rd(2'd2, a0(1, 12'hFE0 + 4 * i));
            check("R8 line write words", r_data, 32'hC0DE_0000 + 32'(i));
        end
        rd(2'd3, a0(1, 12'hFE0));
        for (int i = 0; i < 8; i++) check("R8 line read half1", r_line[32*i +: 32], line[32*i +: 32]);
        check("R9 line read rdata zero", r_data, 32'h0);
        rd(2'd3, a0(0, 12'hFE0));
        for (int i = 0; i < 8; i++) check("R8 line read half0", r_line[32*i +: 32], pat(0, 12'h3F8 + i));

        // R1: addresses outside the window
        rd(2'd2, 32'h8000_0000);
        check("R1 above window", {28'd0, r_flags}, 32'b1100);
        check("R9 miss data zero", r_data, 32'h0);
        rd(2'd2, 32'h7BFF_FFFC);
        check("R1 below window", {28'd0, r_flags}, 32'b1100);
        wr(2'd2, 32'hFC00_0014, 32'hDEAD_BEEF);
        check("R1 high tag alias", {28'd0, r_flags}, 32'b1100);
        rd(2'd2, a0(0, 12'h014));
        check("R1 miss no store", r_data, pat(0, 5));

        // R2: every control value with RAM mode off blocks writes
        off_vals = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
        for (int k = 0; k < 6; k++) begin
            set_ctl(off_vals[k]);
            wr(2'd2, a0(0, 12'h014), 32'hDEAD_BEEF);
            check("R2 mode off unmapped", {28'd0, r_flags}, 32'b1010);
            set_ctl(3'b011);
            rd(2'd2, a0(0, 12'h014));
            check("R2 mode off no store", r_data, pat(0, 5));
        end

        // R10: control write in the request cycle applies from the next one
        req(1'b0, 2'd2, a0(0, 12'h018), '0, '0, 1'b1, 3'b000);
        check("R10 same-cycle ctl old flags", {28'd0, r_flags}, 32'b1000);
        check("R10 same-cycle ctl old data", r_data, pat(0, 6));
        rd(2'd2, a0(0, 12'h018));
        check("R10 next request unmapped", {28'd0, r_flags}, 32'b1010);

        // R9: unmapped outranks misaligned
        rd(2'd2, a0(0, 12'h019));
        check("R9 unmapped over misalign", {28'd0, r_flags}, 32'b1010);

        // R10: contents survive reset
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        set_ctl(3'b111);
        rd(2'd2, a1(1, 12'hFE4));
        check("R10 contents kept over reset", r_data, 32'hC0DE_0001);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule